// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM array out of power-up and then keeps it refreshed. When reset is released it stays quiet for a programmable pause. It then runs a fixed number of refresh cycles back to back on its own, and only after that does it let the host access controller use the memory. In the running phase an interval timer adds one owed refresh every `REF_INTERVAL` clocks. While refreshes are owed, the block asks the access controller for the pins with a request/grant pair. When the grant arrives, it drives one refresh cycle.

Two refresh styles can be chosen at build time. In the default style, CAS falls before RAS, WE stays high, and the DRAM's own row counter picks the row. In the RAS-only style, CAS stays high and the block places a row from its own 12-bit counter on the address bus. Owed refreshes pile up to a limit while the grant is withheld. At that limit the request is flagged urgent, and the host must honour it at its next access boundary.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, RAS and CAS stay high and no request is raised for `PAUSE_CYC` clocks. The first refresh cycle begins its setup in the next clock, so RAS first goes low `PAUSE_CYC+1+T_SETUP` clocks after release.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles run without any request. Successive cycles are one idle clock apart. `init_done` rises in the clock after the last one's precharge ends and stays high. `ref_req` is never high while `init_done` is low.
- R3: In the default style, CAS is low for `T_SETUP` clocks before RAS falls and for the first `T_CHR` clocks of RAS low. It is high for the rest of the cycle. WE is high on every clock and `row_oe` is never asserted.
- R4: In every refresh cycle, RAS is low for exactly `T_RAS` clocks. It is then high for `T_RP` clocks of precharge before the block is idle, and `ref_busy` is high for the whole setup, low and precharge span.
- R5: In RAS-only style, CAS stays high. `row_oe` is high for the `T_SETUP` clocks before RAS falls and for the whole RAS-low time, and `row_addr` holds one value throughout the cycle.
- R6: In RAS-only style, the row counter is 0 after reset. It advances by one after every refresh cycle, initialization cycles included, and wraps from 4095 to 0. In the default style, `row_addr` is 0.
- R7: Once `init_done` is high, one refresh becomes owed every `REF_INTERVAL` clocks. The first is owed at the `REF_INTERVAL`-th clock edge after `init_done` rises.
- R8: `ref_req` is high exactly when `init_done` is high, at least one refresh is owed and no cycle is in progress. A clock edge with `ref_req` and `ref_gnt` both high starts a cycle in the next clock and removes one owed refresh.
- R9: The owed count saturates at `MAX_PENDING`. A tick that arrives while the count is full is dropped. `ref_urgent` is high exactly while the count equals `MAX_PENDING`.
- R10: When the grant latency stays below `MAX_PENDING*REF_INTERVAL` clocks, every retention window of `(ROWS+MAX_PENDING+1)*REF_INTERVAL` clocks contains at least `ROWS` (4096) RAS falling edges.
- R11: While reset is held, RAS, CAS and WE are high, and `ref_req`, `ref_urgent`, `ref_busy`, `init_done` and `row_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Access controller hands the DRAM pins to the sequencer |
| ref_req | output | 1 | A refresh is owed and the sequencer is idle |
| ref_urgent | output | 1 | Owed refresh count has reached its limit |
| ref_busy | output | 1 | Sequencer owns the DRAM pins this clock |
| init_done | output | 1 | Power-up pause and initialization cycles complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| row_oe | output | 1 | Drive `row_addr` onto the address bus (RAS-only style) |
| row_addr | output | ROW_W | Refresh row for RAS-only style |

## Verification
The bench runs one instance in each refresh style against a behavioural queue model. It compares every output on every clock. It measures the clock of the first RAS fall and the clock at which `init_done` rises. An off-by-one pause counter, or one initialization cycle too many or too few, shifts these clocks, and a design that let the host in early raises `ref_req` too soon. The bench withholds the grant long enough to saturate the owed count. A design that wrapped the count or dropped the urgent flag would stop matching the model. The bench also counts RAS falls over a full scaled retention window, and it requires the RAS-only row address to wrap from 4095 to 0. A lost tick or a missing wrap shows up as a short count or a wrong row.

// File: rtl/dram_rfsh_pkg.sv
// Shared types for the refresh sequencer: the per-cycle pin engine states and
// the power-up phase of the top level.
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SETUP,
        ENG_LOW,
        ENG_PRECH
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_e;

endpackage

// File: rtl/rfsh_cycle_engine.sv
// Drives one refresh cycle on the strobes: a setup span, a RAS-low span and a
// RAS precharge span. Assumes start is raised only while busy is low, and
// T_CHR < T_RAS so that CAS is released before RAS rises.
module rfsh_cycle_engine
    import dram_rfsh_pkg::*;
#(
    parameter bit RAS_ONLY = 1'b0,
    parameter int T_SETUP  = 2,
    parameter int T_CHR    = 2,
    parameter int T_RAS    = 7,
    parameter int T_RP     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic cyc_end,
    output logic ras_n,
    output logic cas_n,
    output logic row_oe
);

    localparam int TMAX = (T_RAS > T_RP) ? ((T_RAS > T_SETUP) ? T_RAS : T_SETUP)
                                         : ((T_RP > T_SETUP) ? T_RP : T_SETUP);
    localparam int CW = $clog2(TMAX + 1);

    eng_state_e     st;
    logic [CW-1:0]  cnt;

    // Step through setup, RAS low and precharge, each timed by cnt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ENG_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (start) begin
                        st  <= ENG_SETUP;
                        cnt <= CW'(T_SETUP - 1);
                    end
                end
                ENG_SETUP: begin
                    if (cnt == '0) begin
                        st  <= ENG_LOW;
                        cnt <= CW'(T_RAS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_LOW: begin
                    if (cnt == '0) begin
                        st  <= ENG_PRECH;
                        cnt <= CW'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st <= ENG_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy    = (st != ENG_IDLE);
    assign cyc_end = (st == ENG_PRECH) && (cnt == '0);
    assign ras_n   = (st != ENG_LOW);

    generate
        if (RAS_ONLY) begin : g_ras_only
            assign cas_n  = 1'b1;
            assign row_oe = (st == ENG_SETUP) || (st == ENG_LOW);

            // R5: row address is on the bus before and at the RAS fall
            a_r5_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (row_oe && $past(row_oe)));
        end else begin : g_cbr
            assign cas_n  = !((st == ENG_SETUP) ||
                              ((st == ENG_LOW) && (cnt >= CW'(T_RAS - T_CHR))));
            assign row_oe = 1'b0;

            // R3: CAS already low in the clock before RAS falls and at the fall
            a_r3_cas_setup: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
            // R3: CAS released before RAS rises
            a_r3_cas_release: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ras_n) |-> cas_n);
            if (T_CHR > 1) begin : g_hold
                // R3: CAS still low one clock after the RAS fall
                a_r3_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
                    $fell(ras_n) |=> !cas_n);
            end
        end
        if (T_RP > 1) begin : g_prech
            // R4: RAS stays high at least two clocks after it rises
            a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ras_n) |=> ras_n);
        end
    endgenerate

    // R4: a new cycle never starts while one is running
    a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == ENG_IDLE));

endmodule

// File: rtl/rfsh_pending_tracker.sv
// Counts clocks between refreshes and keeps the number of owed refreshes.
// Assumes en stays low until initialization completes and then stays high.
// The owed count saturates at MAX_PENDING; a tick that arrives while full is dropped.
module rfsh_pending_tracker #(
    parameter int REF_INTERVAL = 1950,
    parameter int MAX_PENDING  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic take,
    output logic pending_nz,
    output logic urgent
);

    localparam int IW = $clog2(REF_INTERVAL);
    localparam int PW = $clog2(MAX_PENDING + 1);

    logic [IW-1:0] ivl;
    logic [PW-1:0] pend;
    logic          tick;

    assign tick = en && (ivl == IW'(REF_INTERVAL - 1));

    // Free-running interval count while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ivl <= '0;
        end else begin
            ivl <= tick ? '0 : ivl + 1'b1;
        end
    end

    // Owed refresh count: add on tick, remove on take, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (tick && !take) begin
            if (pend != PW'(MAX_PENDING)) begin
                pend <= pend + 1'b1;
            end
        end else if (!tick && take) begin
            pend <= pend - 1'b1;
        end
    end

    assign pending_nz = (pend != '0);
    assign urgent     = (pend == PW'(MAX_PENDING));

    // R9: urgency persists until a refresh is taken
    a_r9_urgent_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent && !take) |=> urgent);
    // R8: a take is only possible when something is owed
    a_r8_take_owed: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pending_nz);

endmodule

// File: rtl/rfsh_row_counter.sv
// Row counter used by RAS-only refresh. It advances once per completed refresh
// cycle and wraps naturally at 2**ROW_W.
module rfsh_row_counter #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    // Advance after each finished refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= row + 1'b1;
        end
    end

    // R6: the row only changes by exactly one step
    a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (row != $past(row)) |-> (row == $past(row) + 1'b1));

endmodule

// File: rtl/dram_refresh_seq.sv
// Top of the refresh sequencer. Holds the DRAM idle for a power-up pause and
// then runs INIT_CYCLES refresh cycles. After that it requests the pins once per
// owed refresh. Assumes the access controller raises ref_gnt only at an access
// boundary and keeps off the DRAM pins while ref_busy is high.
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter bit RAS_ONLY     = 1'b0,
    parameter int ROW_W        = 12,
    parameter int PAUSE_CYC    = 25000,
    parameter int INIT_CYCLES  = 8,
    parameter int REF_INTERVAL = 1950,
    parameter int MAX_PENDING  = 8,
    parameter int T_SETUP      = 2,
    parameter int T_CHR        = 2,
    parameter int T_RAS        = 7,
    parameter int T_RP         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             ref_busy,
    output logic             init_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             row_oe,
    output logic [ROW_W-1:0] row_addr
);

    localparam int PCW = $clog2(PAUSE_CYC);
    localparam int ICW = $clog2(INIT_CYCLES + 1);

    phase_e          ph;
    logic [PCW-1:0]  pause_cnt;
    logic [ICW-1:0]  init_cnt;
    logic            eng_busy;
    logic            cyc_end;
    logic            start;
    logic            take;
    logic            pend_nz;

    assign take    = ref_req && ref_gnt;
    assign start   = ((ph == PH_INIT) && !eng_busy) || take;
    assign ref_req = (ph == PH_RUN) && pend_nz && !eng_busy;
    assign init_done = (ph == PH_RUN);
    assign ref_busy  = eng_busy;
    assign we_n      = 1'b1;

    // Power-up phase: pause, then count initialization cycles, then run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_PAUSE;
            pause_cnt <= '0;
            init_cnt  <= '0;
        end else begin
            case (ph)
                PH_PAUSE: begin
                    if (pause_cnt == PCW'(PAUSE_CYC - 1)) begin
                        ph <= PH_INIT;
                    end else begin
                        pause_cnt <= pause_cnt + 1'b1;
                    end
                end
                PH_INIT: begin
                    if (cyc_end) begin
                        if (init_cnt == ICW'(INIT_CYCLES - 1)) begin
                            ph <= PH_RUN;
                        end else begin
                            init_cnt <= init_cnt + 1'b1;
                        end
                    end
                end
                default: ph <= PH_RUN;
            endcase
        end
    end

    rfsh_cycle_engine #(
        .RAS_ONLY (RAS_ONLY),
        .T_SETUP  (T_SETUP),
        .T_CHR    (T_CHR),
        .T_RAS    (T_RAS),
        .T_RP     (T_RP)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (eng_busy),
        .cyc_end (cyc_end),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .row_oe  (row_oe)
    );

    rfsh_pending_tracker #(
        .REF_INTERVAL (REF_INTERVAL),
        .MAX_PENDING  (MAX_PENDING)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (init_done),
        .take       (take),
        .pending_nz (pend_nz),
        .urgent     (ref_urgent)
    );

    generate
        if (RAS_ONLY) begin : g_rows
            rfsh_row_counter #(.ROW_W(ROW_W)) u_rows (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (cyc_end),
                .row   (row_addr)
            );
        end else begin : g_no_rows
            assign row_addr = '0;
        end
    endgenerate

    // R1: the strobes stay quiet during the pause
    a_r1_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_PAUSE) |-> (ras_n && cas_n && !eng_busy));
    // R2: the host is never asked before initialization is done
    a_r2_req_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> init_done);
    // R2: init_done never falls once raised
    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R8: a granted request starts a cycle in the next clock
    a_r8_grant_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (ref_busy && !ref_req));

endmodule

// File: tb/test_dram_refresh_seq.sv
// Behavioural reference: a queue of per-clock pin values for each refresh cycle
// plus integer counters for the pause, initialization and owed refreshes.
module rfsh_ref_model #(
    parameter bit RAS_ONLY     = 1'b0,
    parameter int PAUSE_CYC    = 50,
    parameter int INIT_CYCLES  = 8,
    parameter int REF_INTERVAL = 12,
    parameter int MAX_PENDING  = 4,
    parameter int T_SETUP      = 2,
    parameter int T_CHR        = 2,
    parameter int T_RAS        = 4,
    parameter int T_RP         = 2,
    parameter int ROWS         = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    output logic e_ras, e_cas, e_oe, e_req, e_urg, e_busy, e_done,
    output int   e_row
);
    int q[$];
    int phase = 0, pc = 0, inits = 0, pend = 0, ivl = 0, row = 0;
    bit busy_pre, last, req_pre, take, strt, tick;

    initial begin
        e_ras = 1; e_cas = 1; e_oe = 0; e_req = 0; e_urg = 0; e_busy = 0; e_done = 0; e_row = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); phase = 0; pc = 0; inits = 0; pend = 0; ivl = 0; row = 0;
        end else begin
            busy_pre = (q.size() != 0);
            last     = (q.size() == 1);
            req_pre  = (phase == 2) && (pend > 0) && !busy_pre;
            take     = req_pre && gnt;
            strt     = ((phase == 1) && !busy_pre) || take;
            tick     = (phase == 2) && (ivl == REF_INTERVAL - 1);
            if (phase == 2) ivl = tick ? 0 : ivl + 1;
            if (tick && !take) pend = (pend < MAX_PENDING) ? pend + 1 : pend;
            else if (!tick && take) pend = pend - 1;
            if (busy_pre) void'(q.pop_front());
            if (last) begin
                if (RAS_ONLY) row = (row + 1) % ROWS;
                if (phase == 1) begin
                    inits++;
                    if (inits == INIT_CYCLES) phase = 2;
                end
            end
            if (phase == 0) begin
                if (pc == PAUSE_CYC - 1) phase = 1; else pc++;
            end
            if (strt) begin
                // bit0 ras_n, bit1 cas_n, bit2 row_oe
                for (int k = 0; k < T_SETUP; k++) q.push_back(RAS_ONLY ? 7 : 1);
                for (int k = 0; k < T_RAS; k++)
                    q.push_back(RAS_ONLY ? 6 : ((k < T_CHR) ? 0 : 2));
                for (int k = 0; k < T_RP; k++) q.push_back(3);
            end
        end
        e_ras  = (q.size() != 0) ? q[0][0] : 1'b1;
        e_cas  = (q.size() != 0) ? q[0][1] : 1'b1;
        e_oe   = (q.size() != 0) ? q[0][2] : 1'b0;
        e_busy = (q.size() != 0);
        e_req  = (phase == 2) && (pend > 0) && (q.size() == 0);
        e_urg  = (pend == MAX_PENDING);
        e_done = (phase == 2);
        e_row  = row;
    end
endmodule

module test_dram_refresh_seq;
    localparam int P    = 50;
    localparam int NI   = 8;
    localparam int RI   = 12;
    localparam int MAXP = 4;
    localparam int TS = 2, TC = 2, TR = 4, TP = 2;
    localparam int L    = TS + TR + TP;
    localparam int ROWS = 4096;
    localparam int WIN  = (ROWS + MAXP + 1) * RI;

    logic clk = 0;
    logic rst_n = 0;
    logic gnt_a = 0, gnt_b = 0;
    int   n_chk = 0, n_fail = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    logic a_req, a_urg, a_busy, a_done, a_ras, a_cas, a_we, a_oe;
    logic [11:0] a_row;
    logic b_req, b_urg, b_busy, b_done, b_ras, b_cas, b_we, b_oe;
    logic [11:0] b_row;

    dram_refresh_seq #(.RAS_ONLY(1'b0), .PAUSE_CYC(P), .INIT_CYCLES(NI), .REF_INTERVAL(RI),
        .MAX_PENDING(MAXP), .T_SETUP(TS), .T_CHR(TC), .T_RAS(TR), .T_RP(TP)) i_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_a), .ref_req(a_req), .ref_urgent(a_urg),
        .ref_busy(a_busy), .init_done(a_done), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
        .row_oe(a_oe), .row_addr(a_row));

    dram_refresh_seq #(.RAS_ONLY(1'b1), .PAUSE_CYC(P), .INIT_CYCLES(NI), .REF_INTERVAL(RI),
        .MAX_PENDING(MAXP), .T_SETUP(TS), .T_CHR(TC), .T_RAS(TR), .T_RP(TP)) i_dram_refresh_seq_ro (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_b), .ref_req(b_req), .ref_urgent(b_urg),
        .ref_busy(b_busy), .init_done(b_done), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
        .row_oe(b_oe), .row_addr(b_row));

    logic ea_ras, ea_cas, ea_oe, ea_req, ea_urg, ea_busy, ea_done;
    logic eb_ras, eb_cas, eb_oe, eb_req, eb_urg, eb_busy, eb_done;
    int   ea_row, eb_row;

    rfsh_ref_model #(.RAS_ONLY(1'b0), .PAUSE_CYC(P), .INIT_CYCLES(NI), .REF_INTERVAL(RI),
        .MAX_PENDING(MAXP), .T_SETUP(TS), .T_CHR(TC), .T_RAS(TR), .T_RP(TP), .ROWS(ROWS)) m_a (
        .clk(clk), .rst_n(rst_n), .gnt(gnt_a), .e_ras(ea_ras), .e_cas(ea_cas), .e_oe(ea_oe),
        .e_req(ea_req), .e_urg(ea_urg), .e_busy(ea_busy), .e_done(ea_done), .e_row(ea_row));
    rfsh_ref_model #(.RAS_ONLY(1'b1), .PAUSE_CYC(P), .INIT_CYCLES(NI), .REF_INTERVAL(RI),
        .MAX_PENDING(MAXP), .T_SETUP(TS), .T_CHR(TC), .T_RAS(TR), .T_RP(TP), .ROWS(ROWS)) m_b (
        .clk(clk), .rst_n(rst_n), .gnt(gnt_b), .e_ras(eb_ras), .e_cas(eb_cas), .e_oe(eb_oe),
        .e_req(eb_req), .e_urg(eb_urg), .e_busy(eb_busy), .e_done(eb_done), .e_row(eb_row));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Per-clock comparison of both instances against their models.
    task automatic compare_all();
        chk("R4 ras_n cbr", a_ras, ea_ras);
        chk("R3 cas_n cbr", a_cas, ea_cas);
        chk("R3 we_n cbr", a_we, 1);
        chk("R3 row_oe cbr", a_oe, ea_oe);
        chk("R6 row cbr", a_row, 0);
        chk("R8 req cbr", a_req, ea_req);
        chk("R9 urgent cbr", a_urg, ea_urg);
        chk("R4 busy cbr", a_busy, ea_busy);
        chk("R2 done cbr", a_done, ea_done);
        chk("R4 ras_n ro", b_ras, eb_ras);
        chk("R5 cas_n ro", b_cas, eb_cas);
        chk("R5 row_oe ro", b_oe, eb_oe);
        chk("R6 row ro", b_row, eb_row);
        chk("R8 req ro", b_req, eb_req);
        chk("R9 urgent ro", b_urg, eb_urg);
        chk("R4 busy ro", b_busy, eb_busy);
        chk("R7 done ro", b_done, eb_done);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int n = 0, post = -1, first_fall = -1, done_at = -1, init_falls = 0;
        int win_a = 0, win_b = 0, win_start;
        bit prev_a = 1, prev_b = 1, wrapped = 0;
        int prev_row = 0;
        logic [15:0] lfsr = 16'hACE1;
        win_start = 4 * 0 + 760;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset ras_n", a_ras, 1); chk("R11 reset cas_n", a_cas, 1);
        chk("R11 reset we_n", a_we, 1);   chk("R11 reset req", a_req, 0);
        chk("R11 reset busy", a_busy, 0); chk("R11 reset done", a_done, 0);
        chk("R11 reset urgent", b_urg, 0); chk("R11 reset row_oe", b_oe, 0);
        rst_n = 1;
        while (1) begin
            @(negedge clk);
            n++;
            compare_all();
            if (!a_ras && prev_a && first_fall < 0) first_fall = n;
            if (!a_ras && prev_a && !a_done) init_falls++;
            if (a_done && done_at < 0) begin
                done_at = n;
                post = 0;
                chk("R1 first RAS fall clock", first_fall, P + 1 + TS);
                chk("R2 init cycle count", init_falls, NI);
                chk("R2 init_done clock", done_at, P + 1 + (NI - 1) * (L + 1) + L);
            end
            if (prev_row == 4095 && b_row == 0) wrapped = 1;
            prev_row = b_row;
            if (post >= win_start && post < win_start + WIN) begin
                if (!a_ras && prev_a) win_a++;
                if (!b_ras && prev_b) win_b++;
            end
            prev_a = a_ras; prev_b = b_ras;
            // R9: end of each withheld span must have saturated the owed count
            if (post == 379 || post == 759) begin
                chk("R9 urgent after withhold cbr", a_urg, 1);
                chk("R9 urgent after withhold ro", b_urg, 1);
            end
            // Grant policy for the next edge
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (post < 0 || post < 300) begin
                gnt_a = 1; gnt_b = 1;
            end else if (post < 380 || (post >= 680 && post < 760)) begin
                gnt_a = 0; gnt_b = 0;
            end else begin
                gnt_a = lfsr[0]; gnt_b = lfsr[3];
            end
            if (post >= 0) post++;
            if (post == win_start + WIN + 20) break;
        end
        // R10 retention window counts
        chk("R10 refreshes in window cbr", (win_a >= ROWS) ? 1 : 0, 1);
        chk("R10 refreshes in window ro", (win_b >= ROWS) ? 1 : 0, 1);
        chk("R6 row wrap 4095 to 0 seen", wrapped, 1);
        summary();
    end
endmodule